// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter that sits in front of an 8-way analog input selector. Software requests a conversion by pulsing a start strobe with a 3-bit channel number. The block routes that channel to the selector, holds a sampling window, and then works out the result one bit at a time. For each bit trial it drives a trial code to an external DAC and reads one comparator bit. When all trials are complete it stores the code, sets a completion flag and pulses an interrupt.

The conversion clock is a clock-enable derived from the system clock in two steps. A 2-bit rate field first divides the system clock by 2, 4 or 16 to give a base rate. A second bit then either uses that base rate directly or halves it again. Every conversion has the same length in conversion-clock periods, so the wall-clock time depends only on the rate settings. Those settings are captured when a start is accepted.

Top module: `sar_seq`

## Requirements
- R1: After reset, busy, sampling, done and irq are 0, and result, dac_code and mux_sel are all zero.
- R2: When start_req is high while busy is 0, the start is accepted on that clock edge. mux_sel takes chan_req, busy goes to 1, and sampling stays 1 with dac_code at 00h for exactly the first 12 conversion periods.
- R3: A conversion lasts exactly 160 conversion periods, measured from the accepting edge. The last 4 periods are idle, with dac_code holding the final code. busy falls on the same edge on which done rises.
- R4: A conversion period lasts N system clocks. The base divisor is 2 for rate_sel 00, 4 for 01 and 16 for 11. N equals the base divisor when fadc_full is 1 and twice the base divisor when fadc_full is 0.
- R5: Bit trials run from bit 7 down to bit 0 and last 18 conversion periods each. During a trial, dac_code shows the bits already decided with the trial bit set. At the end of the trial the bit is kept only if cmp_hi is 1, meaning the input is at or above the DAC level. The first trial therefore shows 80h, and the second shows C0h or 40h.
- R6: With an ideal comparator, result equals the input value clamped to the range 00h–FFh. result holds its value until the next conversion completes.
- R7: irq is a single-clock pulse that coincides with the rise of done.
- R8: start_req while busy is ignored. mux_sel, the conversion length and the result are all unchanged.
- R9: done clears on a result_rd pulse or on an accepted start. If completion and result_rd fall in the same cycle, completion wins.
- R10: rate_sel 10 is reserved and behaves exactly like 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Conversion request strobe |
| chan_req | input | 3 | Channel to convert |
| rate_sel | input | 2 | Base clock divisor select |
| fadc_full | input | 1 | 1: conversion clock = base rate; 0: base rate halved |
| result_rd | input | 1 | Read strobe for the result register, clears done |
| cmp_hi | input | 1 | Comparator: input at or above DAC level |
| dac_code | output | 8 | Trial code to the external DAC |
| mux_sel | output | 3 | Channel select to the analog selector |
| sampling | output | 1 | Sampling window active |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Result available |
| result | output | 8 | Latched conversion result |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
Some rules are checked by the assertions on every cycle. irq is a one-cycle pulse that only appears with done. busy falls together with the completion pulse. The stored result matches the final DAC code. A start arriving mid-conversion leaves the channel select unchanged. The DAC code stays frozen while the block is idle. Other behaviour can only be shown by the bench's scenarios, which use a behavioural comparator. These are the exact period counts for each rate setting, the 12-period sampling window, the MSB-first decision sequence, clamping at both ends of the range, and the ways done can be cleared.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int RES_W        = 8;
    localparam int CH_W         = 3;
    localparam int TOTAL_TICKS  = 160;
    localparam int SAMPLE_TICKS = 12;
    localparam int TRIAL_TICKS  = (TOTAL_TICKS - SAMPLE_TICKS) / RES_W;
    localparam int SPARE_TICKS  = TOTAL_TICKS - SAMPLE_TICKS - RES_W * TRIAL_TICKS;
    localparam int PHI_DIV_A    = 2;
    localparam int PHI_DIV_B    = 4;
    localparam int PHI_DIV_C    = 16;
    localparam int MAX_RATIO    = 2 * PHI_DIV_C;
    localparam int DIV_W        = $clog2(MAX_RATIO);
    localparam int CNT_W        = $clog2(TOTAL_TICKS);

    typedef enum logic [1:0] {
        RATE_DIV2  = 2'b00,
        RATE_DIV4  = 2'b01,
        RATE_RSVD  = 2'b10,
        RATE_DIV16 = 2'b11
    } rate_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_TRIAL,
        PH_SETTLE
    } phase_e;

    // System clocks per conversion period; the reserved code folds onto the slowest rate.
    function automatic int unsigned div_ratio(input logic [1:0] sel, input logic full);
        int unsigned phi;
        case (rate_e'(sel))
            RATE_DIV2: phi = PHI_DIV_A;
            RATE_DIV4: phi = PHI_DIV_B;
            default:   phi = PHI_DIV_C;
        endcase
        return full ? phi : 2 * phi;
    endfunction

endpackage

// File: rtl/sar_rate_div.sv
module sar_rate_div
    import sar_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic [1:0] rate_sel,
    input  logic       fadc_full,
    output logic       tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            lim <= '0;
        end else if (restart) begin
            cnt <= '0;
            lim <= DIV_W'(div_ratio(rate_sel, fadc_full) - 1);
        end else if (cnt == lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == lim);

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int W = RES_W
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic tick,
    output logic sar_clr,
    output logic sar_load,
    output logic sar_step,
    output logic finish,
    output logic busy,
    output logic sampling
);

    localparam int IDX_W = $clog2(W);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic             samp_end, trial_end, last_bit, settle_end;

    always_comb begin
        samp_end   = tick && (phase == PH_SAMPLE) && (cnt == CNT_W'(SAMPLE_TICKS - 1));
        trial_end  = tick && (phase == PH_TRIAL)  && (cnt == CNT_W'(TRIAL_TICKS - 1));
        last_bit   = (idx == IDX_W'(W - 1));
        settle_end = tick && (phase == PH_SETTLE) && (cnt == CNT_W'(SPARE_TICKS - 1));
        sar_clr    = accept;
        sar_load   = samp_end;
        sar_step   = trial_end;
        finish     = (SPARE_TICKS == 0) ? (trial_end && last_bit) : settle_end;
        busy       = (phase != PH_IDLE);
        sampling   = (phase == PH_SAMPLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            idx   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (accept) begin
                    phase <= PH_SAMPLE;
                    cnt   <= '0;
                    idx   <= '0;
                end
                PH_SAMPLE: if (tick) begin
                    if (samp_end) begin
                        phase <= PH_TRIAL;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_TRIAL: if (tick) begin
                    if (trial_end) begin
                        cnt <= '0;
                        if (last_bit) phase <= (SPARE_TICKS == 0) ? PH_IDLE : PH_SETTLE;
                        else          idx   <= idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: if (tick) begin
                    if (settle_end) phase <= PH_IDLE;
                    else            cnt   <= cnt + 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/sar_approx.sv
module sar_approx
    import sar_pkg::*;
#(
    parameter int W = RES_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic         step,
    input  logic         cmp_hi,
    output logic [W-1:0] code
);

    logic [W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            code <= '0;
            mask <= '0;
        end else if (load) begin
            mask <= {1'b1, {(W-1){1'b0}}};
            code <= {1'b1, {(W-1){1'b0}}};
        end else if (step) begin
            // keep or drop the bit under trial, then raise the next one
            code <= (cmp_hi ? code : (code & ~mask)) | (mask >> 1);
            mask <= mask >> 1;
        end
    end

endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int W  = RES_W,
    parameter int CW = CH_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_req,
    input  logic [CW-1:0] chan_req,
    input  logic [1:0]    rate_sel,
    input  logic          fadc_full,
    input  logic          result_rd,
    input  logic          cmp_hi,
    output logic [W-1:0]  dac_code,
    output logic [CW-1:0] mux_sel,
    output logic          sampling,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  result,
    output logic          irq
);

    logic accept, tick, sar_clr, sar_load, sar_step, finish;

    assign accept = start_req && !busy;

    sar_rate_div u_div (
        .clk       (clk),
        .rst       (rst),
        .restart   (accept),
        .rate_sel  (rate_sel),
        .fadc_full (fadc_full),
        .tick      (tick)
    );

    sar_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .tick     (tick),
        .sar_clr  (sar_clr),
        .sar_load (sar_load),
        .sar_step (sar_step),
        .finish   (finish),
        .busy     (busy),
        .sampling (sampling)
    );

    sar_approx #(.W(W)) u_sar (
        .clk    (clk),
        .rst    (rst),
        .clr    (sar_clr),
        .load   (sar_load),
        .step   (sar_step),
        .cmp_hi (cmp_hi),
        .code   (dac_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            irq     <= 1'b0;
            result  <= '0;
            mux_sel <= '0;
        end else begin
            irq <= finish;
            if (finish) begin
                done   <= 1'b1;
                result <= dac_code;
            end else if (accept || result_rd) begin
                done <= 1'b0;
            end
            if (accept) mux_sel <= chan_req;
        end
    end

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int W  = 8,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          start_req,
    input logic          busy,
    input logic          sampling,
    input logic          done,
    input logic          irq,
    input logic [W-1:0]  dac_code,
    input logic [W-1:0]  result,
    input logic [CW-1:0] mux_sel
);

    assert_irq_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> done);

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_busy_ends_on_finish_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && irq));

    assert_result_is_final_code_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (result == dac_code));

    assert_chan_held_when_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start_req) |=> $stable(mux_sel));

    assert_sample_only_after_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sampling) |-> $past(start_req));

    assert_dac_frozen_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start_req) |=> $stable(dac_code));

endmodule

bind sar_seq sar_seq_chk #(.W(W), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .busy      (busy),
    .sampling  (sampling),
    .done      (done),
    .irq       (irq),
    .dac_code  (dac_code),
    .result    (result),
    .mux_sel   (mux_sel)
);

// File: tb/tb_sar_seq.sv
module tb_sar_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_req = 1'b0;
    logic [2:0] chan_req = '0;
    logic [1:0] rate_sel = '0;
    logic       fadc_full = 1'b1;
    logic       result_rd = 1'b0;
    logic       cmp_hi;
    logic [7:0] dac_code, result;
    logic [2:0] mux_sel;
    logic       sampling, busy, done, irq;
    int         vin = 0;

    int nchk  = 0;
    int nfail = 0;

    typedef struct { int ch; int val; } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    // behavioural comparator
    assign cmp_hi = (vin >= int'(dac_code));

    sar_seq dut (
        .clk(clk), .rst(rst), .start_req(start_req), .chan_req(chan_req),
        .rate_sel(rate_sel), .fadc_full(fadc_full), .result_rd(result_rd),
        .cmp_hi(cmp_hi), .dac_code(dac_code), .mux_sel(mux_sel),
        .sampling(sampling), .busy(busy), .done(done), .result(result), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // driver: pushes the expected item, starts a conversion and checks its timing
    task automatic run_conv(input int ch, input int v, input logic [1:0] sel,
                            input logic full, input int poke);
        int n, cyc, expv, t1;
        n    = ((sel == 2'b00) ? 2 : (sel == 2'b01) ? 4 : 16) * (full ? 1 : 2);
        expv = (v < 0) ? 0 : (v > 255) ? 255 : v;
        t1   = (expv >= 128) ? 8'hC0 : 8'h40;
        @(negedge clk);
        vin = v; chan_req = 3'(ch); rate_sel = sel; fadc_full = full;
        exp_q.push_back('{ch, expv});
        start_req = 1'b1;
        @(posedge clk);
        cyc = 0;
        forever begin
            @(negedge clk);
            start_req = 1'b0;
            if (cyc == 0) begin
                chk(busy && sampling, "R2 busy+sampling at start", {busy, sampling}, 3);
                chk(!done, "R9 done cleared by start", done, 0);
            end
            if (cyc == 12*n - 1) chk(sampling && dac_code == 0, "R2 sampling window end", sampling, 1);
            if (cyc == 12*n) begin
                chk(!sampling, "R2 sampling off", sampling, 0);
                chk(dac_code == 8'h80, "R5 first trial code", dac_code, 8'h80);
            end
            if (cyc == 30*n) chk(dac_code == 8'(t1), "R5 second trial code", dac_code, t1);
            if (cyc == 156*n) chk(dac_code == 8'(expv), "R3 idle tail holds code", dac_code, expv);
            if (done || cyc > 160*n + 4) break;
            if (cyc == poke) begin
                start_req = 1'b1;
                chan_req  = 3'd6;
            end
            @(posedge clk);
            cyc++;
        end
        chk(cyc == 160*n, "R3 R4 conversion length", cyc, 160*n);
        chk(!busy, "R3 busy low at completion", busy, 0);
    endtask

    // monitor: pops expected items as results appear
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && irq) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected irq", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(int'(result) == e.val, "R6 result value", result, e.val);
                    chk(int'(mux_sel) == e.ch, "R8 channel kept", mux_sel, e.ch);
                    chk(done, "R7 irq with done", done, 1);
                end
                @(negedge clk);
                chk(!irq, "R7 irq single cycle", irq, 0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !sampling && !done && !irq, "R1 flags after reset",
            {busy, sampling, done, irq}, 0);
        chk(result == 0 && dac_code == 0 && mux_sel == 0, "R1 data after reset",
            int'(result) + int'(dac_code) + int'(mux_sel), 0);

        run_conv(5, 173, 2'b00, 1'b1, -1);   // N = 2
        run_conv(1, -7,  2'b01, 1'b0, -1);   // N = 8, clamps low (R6)
        run_conv(7, 300, 2'b11, 1'b1, -1);   // N = 16, clamps high (R6)
        run_conv(3, 1,   2'b10, 1'b1, -1);   // reserved code acts as 11 (R10)
        run_conv(0, 254, 2'b00, 1'b0, -1);   // N = 4
        run_conv(4, 85,  2'b11, 1'b0, -1);   // N = 32
        run_conv(2, 77,  2'b01, 1'b1, 100);  // start while busy ignored (R8)

        // R9: read strobe clears done, result keeps its value
        @(negedge clk);
        chk(done, "R9 done set before read", done, 1);
        result_rd = 1'b1;
        @(negedge clk);
        result_rd = 1'b0;
        chk(!done, "R9 done cleared by read", done, 0);
        chk(result == 8'd77, "R6 result holds after read", result, 77);

        // R9: new start clears done (checked inside run_conv at cycle 0)
        run_conv(6, 128, 2'b00, 1'b1, -1);
        run_conv(6, 127, 2'b00, 1'b1, -1);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule